// File: doc/BRIEF.md
# Two-Level Tag Presence Detector

This block answers one question for a processor address: is its tag present in a small first-level tag store, in a larger second-level tag store, or in neither? It holds tags only, with no data array behind them, so its whole output is a hit or miss verdict plus two running statistics counters. A request is taken when the block is ready. A single scan counter, stepping once per clock, then walks the first-level tags and afterwards the second-level tags. The first matching entry ends the lookup early. A one-cycle done pulse carries exactly one of three verdict flags.

The stores keep themselves filled. A second-level hit copies the tag into the first level. A miss in both levels installs the tag into both. Each level has its own wrap-around replacement pointer, so the oldest installation is overwritten first. Every entry carries a valid bit, which reset clears. Two saturating counters record hits and misses, and a synchronous clear input zeroes both.

Top module: `tag_miss_detector`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, both counters read 0, and every entry is invalid, so the first lookup of any address reports a miss.
- R2: A request (`req_valid` high while `ready` is 1) is accepted on that clock edge and `ready` drops until the verdict. While busy, `req_valid` is ignored: it produces no extra verdict and installs no tag.
- R3: `done` is high for a single cycle per lookup, and in that cycle exactly one of `l1_hit`, `l2_hit`, `miss` is 1. All three are 0 whenever `done` is 0.
- R4: An address whose tag is valid in the first-level store reports `l1_hit`.
- R5: An address present only in the second level reports `l2_hit`, and its tag is copied into the first level, so an immediate repeat reports `l1_hit`.
- R6: A miss in both levels installs the tag into both stores, so an immediate repeat reports `l1_hit`.
- R7: Each level replaces entries in wrap-around order. After as many further installations into a level as it has entries, an earlier tag is gone from that level: it reports `l2_hit` once gone from the first level only, and `miss` once gone from both.
- R8: A hit needs equality of all `ADDR_W` tag bits. An address differing only in bit `ADDR_W-1` misses.
- R9: `hit_count` counts `l1_hit` plus `l2_hit` verdicts and `miss_count` counts `miss` verdicts. Both are updated on the edge that raises `done` and stop at all-ones.
- R10: `cnt_clr` high on a clock edge zeroes both counters on that edge, even if a count would also have occurred there.
- R11: The scan visits first-level entry k on the (k+1)-th edge after acceptance. A hit at first-level entry 0 raises `done` 1 edge after acceptance, and a full miss raises it L1 depth + L2 depth edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Address whose tag is looked up |
| ready | output | 1 | Block is idle and can accept a request |
| done | output | 1 | One-cycle verdict strobe |
| l1_hit | output | 1 | Verdict: found in first level |
| l2_hit | output | 1 | Verdict: found only in second level |
| miss | output | 1 | Verdict: found in neither level |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bound checker watches the verdict strobe on every cycle: one flag per done pulse, silent flags otherwise, no back-to-back pulses, loss of ready after acceptance, counters that only rise unless cleared, and the clear itself. What the stores hold over time is beyond these properties. Promotion into the first level, installation after a double miss, wrap-around eviction, full-width tag equality, ignored requests while busy, scan latency and counter saturation are all shown by the bench. It runs each lookup against its own model of both stores.

// File: rtl/tag_probe_pkg.sv
package tag_probe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN1 = 2'd1,
      ST_SCAN2 = 2'd2
   } probe_state_t;
endpackage

// File: rtl/tag_bank.sv
module tag_bank #(
   parameter int TAG_W = 22,
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] probe_tag,
   output logic             match
);
   localparam int DEPTH = 1 << IDX_W;

   logic [TAG_W-1:0] tag_mem [DEPTH];
   logic [DEPTH-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (wr_en) tag_mem[wr_idx] <= wr_tag;
   end

   // One valid flop per entry, cleared by reset.
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_valid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               valid_q[g] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               valid_q[g] <= 1'b1;
         end
      end
   endgenerate

   assign match = valid_q[rd_idx] && (tag_mem[rd_idx] == probe_tag);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] CEIL = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else if (clr)
         value <= '0;
      else if (inc && (value != CEIL))
         value <= value + 1'b1;
   end
endmodule

// File: rtl/tag_miss_detector.sv
module tag_miss_detector #(
   parameter int ADDR_W   = 22,
   parameter int L2_IDX_W = 10,
   parameter int L1_IDX_W = 8,
   parameter int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              ready,
   output logic              done,
   output logic              l1_hit,
   output logic              l2_hit,
   output logic              miss,
   input  logic              cnt_clr,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   import tag_probe_pkg::*;

   localparam int L1_DEPTH = 1 << L1_IDX_W;
   localparam int L2_DEPTH = 1 << L2_IDX_W;
   localparam logic [L2_IDX_W-1:0] L1_LAST = L2_IDX_W'(L1_DEPTH - 1);
   localparam logic [L2_IDX_W-1:0] L2_LAST = L2_IDX_W'(L2_DEPTH - 1);

   generate
      if (L1_IDX_W < 1 || L1_IDX_W > L2_IDX_W) begin : g_bad_depth
         $error("tag_miss_detector: L1_IDX_W must be 1..L2_IDX_W");
      end
      if (ADDR_W < 2 || CNT_W < 1) begin : g_bad_width
         $error("tag_miss_detector: ADDR_W >= 2 and CNT_W >= 1 required");
      end
   endgenerate

   probe_state_t          state_q;
   logic [L2_IDX_W-1:0]   scan_q;
   logic [ADDR_W-1:0]     tag_q;
   logic [L1_IDX_W-1:0]   l1_ptr_q;
   logic [L2_IDX_W-1:0]   l2_ptr_q;
   logic                  done_q, l1_hit_q, l2_hit_q, miss_q;
   logic                  l1_match, l2_match;
   logic                  found1, end1, found2, lost;
   logic                  l1_we, l2_we;

   tag_bank #(.TAG_W(ADDR_W), .IDX_W(L1_IDX_W)) u_l1 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(l1_we), .wr_idx(l1_ptr_q), .wr_tag(tag_q),
      .rd_idx(scan_q[L1_IDX_W-1:0]), .probe_tag(tag_q),
      .match(l1_match)
   );

   tag_bank #(.TAG_W(ADDR_W), .IDX_W(L2_IDX_W)) u_l2 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(l2_we), .wr_idx(l2_ptr_q), .wr_tag(tag_q),
      .rd_idx(scan_q), .probe_tag(tag_q),
      .match(l2_match)
   );

   always_comb begin
      found1 = (state_q == ST_SCAN1) && l1_match;
      end1   = (state_q == ST_SCAN1) && (scan_q == L1_LAST);
      found2 = (state_q == ST_SCAN2) && l2_match;
      lost   = (state_q == ST_SCAN2) && !l2_match && (scan_q == L2_LAST);
      l1_we  = found2 || lost;   // promote or install
      l2_we  = lost;             // install only
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         scan_q   <= '0;
         tag_q    <= '0;
         l1_ptr_q <= '0;
         l2_ptr_q <= '0;
         done_q   <= 1'b0;
         l1_hit_q <= 1'b0;
         l2_hit_q <= 1'b0;
         miss_q   <= 1'b0;
      end else begin
         done_q   <= found1 || found2 || lost;
         l1_hit_q <= found1;
         l2_hit_q <= found2;
         miss_q   <= lost;
         if (l1_we) l1_ptr_q <= l1_ptr_q + 1'b1;
         if (l2_we) l2_ptr_q <= l2_ptr_q + 1'b1;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  tag_q   <= req_addr;
                  scan_q  <= '0;
                  state_q <= ST_SCAN1;
               end
            end
            ST_SCAN1: begin
               if (found1) begin
                  state_q <= ST_IDLE;
               end else if (end1) begin
                  scan_q  <= '0;
                  state_q <= ST_SCAN2;
               end else begin
                  scan_q  <= scan_q + 1'b1;
               end
            end
            ST_SCAN2: begin
               if (found2 || lost) state_q <= ST_IDLE;
               else                scan_q  <= scan_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sat_counter #(.W(CNT_W)) u_hits (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .inc(found1 || found2), .value(hit_count)
   );

   sat_counter #(.W(CNT_W)) u_misses (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .inc(lost), .value(miss_count)
   );

   assign ready  = (state_q == ST_IDLE);
   assign done   = done_q;
   assign l1_hit = l1_hit_q;
   assign l2_hit = l2_hit_q;
   assign miss   = miss_q;
endmodule

// File: rtl/tag_miss_detector_chk.sv
module tag_miss_detector_chk #(
   parameter int ADDR_W = 22,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              ready,
   input logic              done,
   input logic              l1_hit,
   input logic              l2_hit,
   input logic              miss,
   input logic              cnt_clr,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones({l1_hit, l2_hit, miss}) == 1)); // R3
   AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ({l1_hit, l2_hit, miss} == 3'b000)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |=> !ready); // R2
   AST_IDLE_AT_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready); // R2
   AST_HITS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (hit_count >= $past(hit_count))); // R9
   AST_MISSES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (miss_count >= $past(miss_count))); // R9
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> ((hit_count == '0) && (miss_count == '0))); // R10
   AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |-> !$isunknown(req_addr)); // R2
endmodule

bind tag_miss_detector tag_miss_detector_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .ready(ready), .done(done), .l1_hit(l1_hit), .l2_hit(l2_hit), .miss(miss),
   .cnt_clr(cnt_clr), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_tag_miss_detector.sv
`timescale 1ns/1ps
module sim_tag_miss_detector;
   localparam int AW  = 22;
   localparam int L1W = 2;
   localparam int L2W = 3;
   localparam int CW  = 4;
   localparam int D1  = 1 << L1W;
   localparam int D2  = 1 << L2W;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          cnt_clr = 1'b0;
   logic          ready, done, l1_hit, l2_hit, miss;
   logic [CW-1:0] hit_count, miss_count;

   tag_miss_detector #(.ADDR_W(AW), .L2_IDX_W(L2W), .L1_IDX_W(L1W), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .ready(ready), .done(done), .l1_hit(l1_hit), .l2_hit(l2_hit), .miss(miss),
      .cnt_clr(cnt_clr), .hit_count(hit_count), .miss_count(miss_count)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // Reference model of both stores, built from the requirements.
   logic [AW-1:0] m1 [D1];
   logic [AW-1:0] m2 [D2];
   bit            v1 [D1];
   bit            v2 [D2];
   int            p1 = 0, p2 = 0;
   int            exp_hits = 0, exp_miss = 0;

   localparam logic [AW-1:0] ADDR_A = 22'h2A_5C31;
   localparam logic [AW-1:0] ADDR_B = 22'h01_0F0F;
   localparam logic [AW-1:0] ADDR_C = 22'h15_7777;

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int predict(input logic [AW-1:0] a);
      int r = 2;
      for (int i = 0; i < D1; i++) if (v1[i] && m1[i] == a) r = 0;
      if (r != 0) for (int i = 0; i < D2; i++) if (v2[i] && m2[i] == a) r = 1;
      if (r != 0) begin
         m1[p1] = a; v1[p1] = 1'b1; p1 = (p1 + 1) % D1;
      end
      if (r == 2) begin
         m2[p2] = a; v2[p2] = 1'b1; p2 = (p2 + 1) % D2;
         exp_miss++;
      end else begin
         exp_hits++;
      end
      return r;
   endfunction

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   // Wait for the verdict; lat counts edges after the accepting edge.
   task automatic wait_verdict(output int kind, output int lat);
      lat = 0;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
      end
      kind = l1_hit ? 0 : (l2_hit ? 1 : (miss ? 2 : 3));
   endtask

   task automatic lookup(input logic [AW-1:0] a, input string req,
                         output int kind, output int lat);
      int ek;
      @(negedge clk);
      chk(req, "ready before request", ready, 1);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      wait_verdict(kind, lat);
      ek = predict(a);
      chk(req, "verdict vs model (0=L1,1=L2,2=miss)", kind, ek);
      chk("R9", "hit_count", hit_count, sat(exp_hits));
      chk("R9", "miss_count", miss_count, sat(exp_miss));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", ready, 1);
      chk("R1", "done after reset", done, 0);
      chk("R1", "hit_count after reset", hit_count, 0);
      chk("R1", "miss_count after reset", miss_count, 0);
   endtask

   task automatic t_cold_and_repeat();
      int k, lat;
      lookup(ADDR_A, "R1", k, lat);
      chk("R1", "first lookup misses", k, 2);
      chk("R11", "miss latency", lat, D1 + D2);
      lookup(ADDR_A, "R6", k, lat);
      chk("R6", "installed tag hits first level", k, 0);
      chk("R4", "first-level hit flag", k, 0);
      chk("R11", "hit at entry 0 latency", lat, 1);
   endtask

   task automatic t_full_width();
      int k, lat;
      lookup(ADDR_A ^ (22'h1 << (AW - 1)), "R8", k, lat);
      chk("R8", "top-bit difference misses", k, 2);
   endtask

   task automatic t_busy_ignore();
      int k, lat, ek, extra;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ADDR_B;
      @(negedge clk);
      req_addr  = ADDR_C;          // held while busy: must be ignored
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_verdict(k, lat);
      ek = predict(ADDR_B);
      chk("R2", "verdict for accepted request", k, ek);
      extra = 0;
      repeat (2 * (D1 + D2) + 4) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk("R2", "no verdict for busy request", extra, 0);
      lookup(ADDR_C, "R2", k, lat);
      chk("R2", "busy request installed nothing", k, 2);
   endtask

   task automatic t_promote();
      int k, lat;
      for (int i = 0; i < D1; i++) lookup(22'h30_0000 + AW'(i), "R7", k, lat);
      lookup(ADDR_A, "R7", k, lat);
      chk("R7", "evicted from first level only", k, 1);
      chk("R5", "second-level hit flag", k, 1);
      lookup(ADDR_A, "R5", k, lat);
      chk("R5", "promoted tag hits first level", k, 0);
   endtask

   task automatic t_l2_evict();
      int k, lat;
      for (int i = 0; i < D2; i++) lookup(22'h3F_0100 + AW'(i), "R7", k, lat);
      lookup(ADDR_A, "R7", k, lat);
      chk("R7", "evicted from both levels", k, 2);
   endtask

   task automatic t_counters();
      int k, lat;
      chk("R9", "miss_count saturated", miss_count, CMAX);
      chk("R9", "hit_count total", hit_count, 3);
      @(negedge clk);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      exp_hits = 0;
      exp_miss = 0;
      chk("R10", "hit_count cleared", hit_count, 0);
      chk("R10", "miss_count cleared", miss_count, 0);
      lookup(ADDR_A, "R10", k, lat);
      chk("R10", "count restarts after clear", hit_count, 1);
   endtask

   initial begin
      for (int i = 0; i < D1; i++) v1[i] = 1'b0;
      for (int i = 0; i < D2; i++) v2[i] = 1'b0;
      t_reset();
      t_cold_and_repeat();
      t_full_width();
      t_busy_ignore();
      t_promote();
      t_l2_evict();
      t_counters();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule